// File: doc/BRIEF.md
# Edge-Latched Address Static RAM

A synthesizable model of a 1024-word by 4-bit static memory whose accesses are framed by an active-low chip enable. The high-to-low transition of the enable starts an access. On that transition the address is copied into an internal register. Until the enable returns high, the address pins are free to change.

The shared data bus is split into a data-in port, a data-out port and an output-enable flag. A read keeps the active-low write enable high. A write pulls it low. The word is committed at the first rising edge of either control while both are low, using the latched address. Holding the write enable low across several enable cycles writes one location per cycle.

The model runs on a system clock. Both control inputs are sampled on each rising clock edge, and their edges are found by comparing each sample with the one before it.

Top module: `sram_elatch`

## Requirements
- R1: The block stores 1024 independent 4-bit words. A word written at any address is read back unchanged later, and writes to other addresses do not alter it.
- R2: The address is captured at the clock edge that first samples `ce_n` low after it was high. Changes on `addr` after that edge do not change the location read or written in that cycle.
- R3: Address bits [9:4] select one of 64 rows and bits [3:0] select one of 16 four-bit column groups. Addresses that differ only in the row field, or only in the column field, never alias.
- R4: While `ce_n` is high, toggling `we_n`, `addr` and `din` changes no stored word and `dout_oe` stays 0.
- R5: With `we_n` high, `dout_oe` goes to 1 at the clock edge that samples `ce_n` low. From then on `dout` carries the word at the latched address until the edge that samples `ce_n` high.
- R6: `dout_oe` is 0 after every clock edge that samples `we_n` low.
- R7: If `we_n` is low before `ce_n` falls and `ce_n` rises first, `dout_oe` stays 0 for the whole cycle. The stored value is the `din` present at the edge that samples `ce_n` high.
- R8: If `ce_n` falls first and `we_n` then pulses low, the word is committed with the `din` present at the edge that samples `we_n` high. At that same edge the output re-enables and shows the newly written word.
- R9: With `we_n` held low across consecutive `ce_n` low pulses, each pulse writes its own latched address.
- R10: Whenever `dout_oe` is 0, `dout` is all zeros.
- R11: After reset `dout_oe` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable; its falling edge starts a cycle |
| we_n | input | 1 | Active-low write enable |
| addr | input | 10 | Word address, row in [9:4], column group in [3:0] |
| din | input | 4 | Write data from the shared bus |
| dout | output | 4 | Read data, zero when not driven |
| dout_oe | output | 1 | High when the block would drive the bus |

## Verification
Reads are run with the address pins scrambled right after the enable edge. A read that returns the right word therefore shows that the latched address, not the live pins, picks the location. Writes are issued in three control orderings: write enable leading, chip enable leading with a write pulse inside, and write enable held low through a burst. Each ordering has its own commit edge and its own output-enable profile, and each is checked for both. Address pairs that differ in only the row field or only the column field show whether the decode aliases. Control and data activity while the enable is high is followed by readback, which shows whether idle cycles leak into the array.

// File: rtl/sram_elatch_pkg.sv
package sram_elatch_pkg;

  // Control events derived from sampled enable and write lines
  typedef struct packed {
    logic e_fall;     // chip enable seen going low
    logic wr_commit;  // first release of W or E while both were low
    logic rd_open;    // enabled with write released
  } sram_evt_t;

endpackage

// File: rtl/sram_el_ctrl.sv
module sram_el_ctrl
  import sram_elatch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce_n,
  input  logic      we_n,
  output sram_evt_t evt
);

  logic ce_q;
  logic we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b1;
      we_q <= 1'b1;
    end else begin
      ce_q <= ce_n;
      we_q <= we_n;
    end
  end

  logic both_low_q;
  logic release_now;

  assign both_low_q    = ~ce_q & ~we_q;
  assign release_now   = ce_n | we_n;

  assign evt.e_fall    = ce_q & ~ce_n;
  assign evt.wr_commit = both_low_q & release_now;
  assign evt.rd_open   = ~ce_n & we_n;

  // R8: a commit is a single-cycle event
  a_r8_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    evt.wr_commit |=> !evt.wr_commit);

  // R2: a cycle start is a single-cycle event
  a_r2_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    evt.e_fall |=> !evt.e_fall);

  // R4: no commit can follow a cycle in which the chip enable was high
  a_r4_idle_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !evt.wr_commit);

endmodule

// File: rtl/sram_el_addr_latch.sv
module sram_el_addr_latch #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_eff
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (capture) addr_q <= addr;
  end

  // Address used during the capture cycle itself, then the held copy
  assign addr_eff = capture ? addr : addr_q;

  // R2: held address only moves at a cycle start
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(addr_q));

endmodule

// File: rtl/sram_el_array.sv
module sram_el_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);

  localparam int ROW_W  = ADDR_W - COL_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int GROUPS = 1 << COL_W;
  localparam int LINE_W = GROUPS * DATA_W;

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] pick_group(input logic [LINE_W-1:0] line,
                                                   input logic [COL_W-1:0]  c);
    return line[c*DATA_W +: DATA_W];
  endfunction

  logic [ROWS-1:0]   wr_row_hit;
  logic [LINE_W-1:0] line_q [ROWS];
  logic [ROW_W-1:0]  wr_row;
  logic [COL_W-1:0]  wr_col;

  assign wr_row = row_of(wr_addr);
  assign wr_col = col_of(wr_addr);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign wr_row_hit[r] = wr_en && (wr_row == ROW_W'(r));

    always_ff @(posedge clk) begin
      if (wr_row_hit[r]) line_q[r][wr_col*DATA_W +: DATA_W] <= wr_data;
    end
  end

  assign rd_word = pick_group(line_q[row_of(rd_addr)], col_of(rd_addr));

  // R3: a write touches exactly one row
  a_r3_one_row: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $countones(wr_row_hit) == 1);

  // R4: no row is selected without a write
  a_r4_no_stray_row: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> wr_row_hit == '0);

endmodule

// File: rtl/sram_elatch.sv
module sram_elatch
  import sram_elatch_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  sram_evt_t         evt;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_eff;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] dout_r;
  logic              oe_r;

  sram_el_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (ce_n),
    .we_n  (we_n),
    .evt   (evt)
  );

  sram_el_addr_latch #(.ADDR_W(ADDR_W)) u_alat (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (evt.e_fall),
    .addr     (addr),
    .addr_q   (addr_q),
    .addr_eff (addr_eff)
  );

  sram_el_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (evt.wr_commit),
    .wr_addr (addr_q),
    .wr_data (din),
    .rd_addr (addr_eff),
    .rd_word (rd_word)
  );

  // Output stage: a commit forwards the written word so a re-enabled bus shows it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_r   <= 1'b0;
      dout_r <= '0;
    end else begin
      oe_r   <= evt.rd_open;
      dout_r <= evt.wr_commit ? din : rd_word;
    end
  end

  assign dout_oe = oe_r;
  assign dout    = oe_r ? dout_r : '0;

  // R4: chip enable high leaves the bus undriven next cycle
  a_r4_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dout_oe);

  // R6: write enable low leaves the bus undriven next cycle
  a_r6_w_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> !dout_oe);

  // R10: undriven bus reads as zero
  a_r10_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == '0);

  // R5: enabled read with no commit keeps the bus driven
  a_r5_read_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n) |=> dout_oe);

endmodule

// File: tb/sram_elatch_tb.sv
module sram_elatch_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1;
  logic       we_n = 1'b1;
  logic [9:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic       dout_oe;

  int checks = 0;
  int fails  = 0;
  logic [3:0] model [1024];
  logic       done = 1'b0;

  always #2 clk = ~clk;

  sram_elatch u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // R7: write enable leads, chip enable releases first
  task automatic write_w_first(input logic [9:0] a, input logic [3:0] d);
    we_n = 1'b0; addr = a; tick();
    ce_n = 1'b0; tick();
    check("R7 oe during write", {7'd0, dout_oe}, 8'd0);
    addr = ~a; din = d; tick();
    check("R7 oe held off", {7'd0, dout_oe}, 8'd0);
    ce_n = 1'b1; tick();
    din = ~d; we_n = 1'b1; tick();
    model[a] = d;
  endtask

  // R8: chip enable leads, write pulse inside the cycle
  task automatic write_e_first(input logic [9:0] a, input logic [3:0] d);
    addr = a; ce_n = 1'b0; tick();
    check("R5 read before write", {7'd0, dout_oe, dout}, {7'd0, 1'b1, model[a]});
    addr = ~a; we_n = 1'b0; din = d; tick();
    check("R6 oe off with W low", {7'd0, dout_oe}, 8'd0);
    check("R10 zero when off", {4'd0, dout}, 8'd0);
    we_n = 1'b1; tick();
    check("R8 reenabled shows new word", {7'd0, dout_oe, dout}, {7'd0, 1'b1, d});
    din = ~d; ce_n = 1'b1; tick();
    model[a] = d;
  endtask

  // R5 R2: read with scrambled address pins after the edge
  task automatic read_chk(input logic [9:0] a, input string req);
    addr = a; we_n = 1'b1; ce_n = 1'b0; tick();
    addr = ~a;
    check(req, {7'd0, dout_oe, dout}, {7'd0, 1'b1, model[a]});
    tick();
    check("R2 held through addr change", {4'd0, dout}, {4'd0, model[a]});
    ce_n = 1'b1; tick();
    check("R10 off after E high", {7'd0, dout_oe, dout}, 8'd0);
  endtask

  // R9: burst of writes with W held low
  task automatic burst(input logic [9:0] base, input int n);
    we_n = 1'b0; tick();
    for (int i = 0; i < n; i++) begin
      addr = base + 10'(i * 37); ce_n = 1'b0; tick();
      check("R9 oe off in burst", {7'd0, dout_oe}, 8'd0);
      din = 4'(i + 5); ce_n = 1'b1;
      model[base + 10'(i * 37)] = 4'(i + 5);
      tick();
    end
    we_n = 1'b1; tick();
    for (int i = 0; i < n; i++) read_chk(base + 10'(i * 37), "R9 burst readback");
  endtask

  // R4: activity with E high must not write
  task automatic idle_noise(input logic [9:0] a);
    ce_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      addr = a; din = ~model[a]; we_n = i[0]; tick();
      check("R4 oe stays off", {7'd0, dout_oe}, 8'd0);
    end
    we_n = 1'b1; tick();
    read_chk(a, "R4 unchanged after idle noise");
  endtask

  // R3: row-only and column-only neighbours
  task automatic alias_test();
    write_w_first(10'h2A5, 4'h3);
    write_w_first(10'h2A6, 4'hC);   // column differs
    write_w_first(10'h1A5, 4'h9);   // row differs
    write_w_first(10'h0A5, 4'h6);
    read_chk(10'h2A5, "R3 base word");
    read_chk(10'h2A6, "R3 column neighbour");
    read_chk(10'h1A5, "R3 row neighbour");
    read_chk(10'h0A5, "R3 row neighbour 2");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = 'x;
    tick(); tick();
    check("R11 reset oe", {7'd0, dout_oe}, 8'd0);
    check("R11 reset dout", {4'd0, dout}, 8'd0);
    rst_n = 1'b1; tick();
    // R1: fill every address, then read all back
    for (int i = 0; i < 1024; i++) write_w_first(10'(i), 4'((i * 7) ^ (i >> 4)));
    for (int i = 0; i < 1024; i += 1) read_chk(10'(i), "R1 full readback");
    write_e_first(10'h155, 4'hA);
    read_chk(10'h155, "R8 stored after pulse");
    write_e_first(10'h3FF, 4'h5);
    read_chk(10'h3FF, "R8 top address");
    burst(10'h010, 6);
    idle_noise(10'h155);
    alias_test();
    read_chk(10'h000, "R1 bottom address");
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          fails++;
          $display("FAIL watchdog expired");
        end
      end
      wait (done);
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule